// File: doc/BRIEF.md
# Event-Triggered Two-Channel DAC Buffer Controller

This block sits between a register write port and two digital-to-analog conversion cores. Each channel holds a staging buffer that software fills and an active data register whose value the converter core uses. A start event arrives on a per-channel wire that may be asynchronous to the controller clock. The block resynchronizes that wire and detects the selected edge. It then moves the staged value into the active register once the core reports ready, and issues a one-cycle conversion start to the core.

The block counts a fixed startup interval after each channel is enabled. An event that lands before that interval ends still loads the active register, but no conversion start is issued. When a transfer leaves a channel's buffer empty, the block can emit a one-cycle buffer-empty event, gated by a per-channel output enable, so that an external agent can refill it. The two channels share nothing but the clock, the reset and the write port.

Top module: `evt_dac_ctrl`

## Requirements
- R1: With `start_ie[i]` set and `start_inv[i]` clear, a 0-to-1 change on `start_evt[i]` that is first sampled at clock edge k copies the channel's staging buffer into `active_data` slice i at edge k+2, provided `conv_ready[i]` is high in the cycle before edge k+2.
- R2: With `start_inv[i]` set, only a 1-to-0 change on `start_evt[i]` triggers the channel, with the same latency as R1. A 0-to-1 change then has no effect.
- R3: While `start_ie[i]` is clear, changes on `start_evt[i]` leave `active_data` slice i and `conv_start[i]` unchanged.
- R4: A trigger that arrives while `conv_ready[i]` is low is held as a single pending request. The transfer happens at the first edge where ready is high. Further triggers during the wait add no extra transfer or conversion start.
- R5: `startup_done[i]` goes high once `ch_enable[i]` has been sampled high at `STARTUP_CYC` consecutive edges. It goes low at the edge where `ch_enable[i]` is sampled low.
- R6: A transfer made while `startup_done[i]` is low still loads the active register, but `conv_start[i]` stays low.
- R7: A transfer made while `startup_done[i]` is high pulses `conv_start[i]` for exactly one cycle, at the same edge as the load.
- R8: The channel's buffer-empty flag is set by a transfer and cleared by a buffer write. When it changes from clear to set, `empty_evt[i]` pulses for one cycle if `empty_oe[i]` is high, and it stays low otherwise.
- R9: A write with `wr_to_buf`=0 (the direct target) loads `active_data` slice `wr_chan` at the next edge only while that channel's `start_ie` is clear. A write with `wr_to_buf`=1 targets the staging buffer.
- R10: Events, enables and writes addressed to one channel leave the other channel's outputs unchanged.
- R11: After reset, `active_data`, `conv_start`, `empty_evt` and `startup_done` are all zero, and the buffer-empty flag is set without raising an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | NCH | Per-channel enable; starts the startup count |
| start_ie | input | NCH | Per-channel enable for the start-event action |
| start_inv | input | NCH | Per-channel select of the falling edge as the trigger |
| empty_oe | input | NCH | Per-channel enable for the buffer-empty event |
| start_evt | input | NCH | Asynchronous start event wires |
| conv_ready | input | NCH | Converter core ready for its next conversion |
| wr_valid | input | 1 | Write strobe |
| wr_chan | input | CHW | Channel addressed by the write |
| wr_to_buf | input | 1 | 1 = staging buffer, 0 = active data register |
| wr_data | input | DW | Write value |
| active_data | output | NCH*DW | Active data registers, channel 0 in the low bits |
| conv_start | output | NCH | One-cycle conversion start per channel |
| empty_evt | output | NCH | One-cycle buffer-empty event per channel |
| startup_done | output | NCH | Startup interval complete per channel |

## Verification
The assertions assume that the converter core holds `conv_ready` steady across each cycle boundary. They also assume that the write port never addresses a channel index at or above `NCH`. The stimulus changes the start event wires on the falling clock edge and holds each level for at least three cycles, so that every change passes the synchronizer as one clean edge. Random phases draw values and channels from a seeded generator and keep the ready line high, apart from the directed wait case.

// File: rtl/evt_dac_pkg.sv
package evt_dac_pkg;

  typedef enum logic {
    TGT_DATA = 1'b0,
    TGT_BUF  = 1'b1
  } wr_tgt_e;

  // Qualifying edge of a synchronized level; inv selects the falling edge.
  function automatic logic edge_hit(input logic prev, input logic cur, input logic inv);
    return inv ? (prev & ~cur) : (~prev & cur);
  endfunction

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  input  logic inv,
  input  logic en,
  output logic trig
);
  import evt_dac_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign trig = en & edge_hit(prev_q, sync_q[STAGES-1], inv);

endmodule

// File: rtl/evt_startup_timer.sv
module evt_startup_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(CYCLES)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == CW'(CYCLES));

endmodule

// File: rtl/evt_dac_channel.sv
module evt_dac_channel #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          ready,
  input  logic          started,
  input  logic          ie,
  input  logic          oe,
  input  logic          wr_buf,
  input  logic          wr_dat,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] data,
  output logic          conv_start,
  output logic          empty_evt
);
  logic [DW-1:0] buf_q;
  logic [DW-1:0] data_q;
  logic          pend_q;
  logic          empty_q;
  logic          cs_q;
  logic          ev_q;
  logic          want;
  logic          go;
  logic          empty_nxt;

  assign want      = trig | pend_q;
  assign go        = want & ready;
  assign empty_nxt = wr_buf ? 1'b0 : (go ? 1'b1 : empty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
      cs_q    <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      pend_q  <= want & ~ready;
      cs_q    <= go & started;
      empty_q <= empty_nxt;
      ev_q    <= oe & empty_nxt & ~empty_q;
      if (wr_buf) buf_q <= wr_data;
      if (go) begin
        data_q <= buf_q;
      end else if (wr_dat && !ie) begin
        data_q <= wr_data;
      end
    end
  end

  assign data       = data_q;
  assign conv_start = cs_q;
  assign empty_evt  = ev_q;

endmodule

// File: rtl/evt_dac_ctrl.sv
module evt_dac_ctrl #(
  parameter int NCH         = 2,
  parameter int DW          = 12,
  parameter int SYNC_STAGES = 2,
  parameter int STARTUP_CYC = 8,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ch_enable,
  input  logic [NCH-1:0]    start_ie,
  input  logic [NCH-1:0]    start_inv,
  input  logic [NCH-1:0]    empty_oe,
  input  logic [NCH-1:0]    start_evt,
  input  logic [NCH-1:0]    conv_ready,
  input  logic              wr_valid,
  input  logic [CHW-1:0]    wr_chan,
  input  logic              wr_to_buf,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] active_data,
  output logic [NCH-1:0]    conv_start,
  output logic [NCH-1:0]    empty_evt,
  output logic [NCH-1:0]    startup_done
);
  import evt_dac_pkg::*;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic trig;
    logic hit;
    logic wr_b;
    logic wr_d;

    assign hit  = wr_valid && (wr_chan == CHW'(i));
    assign wr_b = hit && (wr_tgt_e'(wr_to_buf) == TGT_BUF);
    assign wr_d = hit && (wr_tgt_e'(wr_to_buf) == TGT_DATA);

    evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (start_evt[i]),
      .inv      (start_inv[i]),
      .en       (start_ie[i]),
      .trig     (trig)
    );

    evt_startup_timer #(.CYCLES(STARTUP_CYC)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .en   (ch_enable[i]),
      .done (startup_done[i])
    );

    evt_dac_channel #(.DW(DW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .trig       (trig),
      .ready      (conv_ready[i]),
      .started    (startup_done[i]),
      .ie         (start_ie[i]),
      .oe         (empty_oe[i]),
      .wr_buf     (wr_b),
      .wr_dat     (wr_d),
      .wr_data    (wr_data),
      .data       (active_data[i*DW +: DW]),
      .conv_start (conv_start[i]),
      .empty_evt  (empty_evt[i])
    );
  end

endmodule

// File: rtl/evt_dac_ctrl_chk.sv
module evt_dac_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_enable,
  input logic [NCH-1:0] empty_oe,
  input logic [NCH-1:0] conv_ready,
  input logic [NCH-1:0] conv_start,
  input logic [NCH-1:0] empty_evt,
  input logic [NCH-1:0] startup_done
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R4
    start_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
      conv_start[i] |-> $past(conv_ready[i]));
    // R6
    start_after_startup_chk: assert property (@(posedge clk) disable iff (rst)
      conv_start[i] |-> $past(startup_done[i]));
    // R8
    empty_evt_gated_chk: assert property (@(posedge clk) disable iff (rst)
      empty_evt[i] |-> $past(empty_oe[i]));
    // R8
    empty_evt_single_chk: assert property (@(posedge clk) disable iff (rst)
      empty_evt[i] |=> !empty_evt[i]);
    // R5
    done_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      startup_done[i] |-> $past(ch_enable[i]));
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !ch_enable[i] |=> !startup_done[i]);
  end
endmodule

bind evt_dac_ctrl evt_dac_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ch_enable    (ch_enable),
  .empty_oe     (empty_oe),
  .conv_ready   (conv_ready),
  .conv_start   (conv_start),
  .empty_evt    (empty_evt),
  .startup_done (startup_done)
);

// File: tb/evt_dac_ctrl_test.sv
module evt_dac_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int DW  = 12;
  localparam int SU  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ch_enable = '0, start_ie = '0, start_inv = '0, empty_oe = '0;
  logic [NCH-1:0] start_evt = '0, conv_ready = '1;
  logic wr_valid = 1'b0, wr_chan = 1'b0, wr_to_buf = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [NCH*DW-1:0] active_data;
  logic [NCH-1:0] conv_start, empty_evt, startup_done;

  int errors = 0;
  int checks = 0;
  int cs_cnt [NCH];
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_dac_ctrl #(.NCH(NCH), .DW(DW), .SYNC_STAGES(2), .STARTUP_CYC(SU)) uut (
    .clk(clk), .rst(rst), .ch_enable(ch_enable), .start_ie(start_ie),
    .start_inv(start_inv), .empty_oe(empty_oe), .start_evt(start_evt),
    .conv_ready(conv_ready), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_to_buf(wr_to_buf), .wr_data(wr_data), .active_data(active_data),
    .conv_start(conv_start), .empty_evt(empty_evt), .startup_done(startup_done)
  );

  always @(negedge clk) begin
    if (!rst) for (int c = 0; c < NCH; c++) if (conv_start[c]) cs_cnt[c]++;
  end

  function automatic logic [DW-1:0] dat(input int c);
    return active_data[c*DW +: DW];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input int c, input bit tobuf, input logic [DW-1:0] v);
    wr_valid = 1'b1; wr_chan = c[0]; wr_to_buf = tobuf; wr_data = v;
    tick();
    wr_valid = 1'b0;
  endtask

  // Drive level, wait the 3 edges after which the transfer is visible.
  task automatic set_evt(input int c, input bit lvl);
    start_evt[c] = lvl;
    tick(3);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, old1;
    int n0;
    void'($urandom(32'h5eed));
    for (int c = 0; c < NCH; c++) cs_cnt[c] = 0;
    @(negedge clk);
    tick(2);
    rst = 1'b0;
    // R11 reset state
    check(active_data == 0 && conv_start == 0 && empty_evt == 0 && startup_done == 0,
          "R11 reset", int'(active_data), 0);

    // R6 event before startup completes: load, no conversion
    empty_oe = '1; start_ie = 2'b01;
    ch_enable[0] = 1'b1;
    wr(0, 1'b1, 12'h1A5);
    set_evt(0, 1'b1);
    check(dat(0) == 12'h1A5, "R6 early load", dat(0), 12'h1A5);
    check(conv_start[0] == 1'b0, "R6 no start", conv_start[0], 0);
    set_evt(0, 1'b0);

    // R5 startup timer
    ch_enable[1] = 1'b1;
    tick(SU - 1);
    check(startup_done[1] == 1'b0, "R5 not yet", startup_done[1], 0);
    tick();
    check(startup_done[1] == 1'b1, "R5 done", startup_done[1], 1);
    check(startup_done[0] == 1'b1, "R5 ch0 done", startup_done[0], 1);

    // R1 R7 R8 rising edge transfer, start pulse, empty event
    wr(0, 1'b1, 12'h3C7);
    start_evt[0] = 1'b1;
    tick(2);
    check(dat(0) == 12'h1A5, "R1 latency", dat(0), 12'h1A5);
    tick();
    check(dat(0) == 12'h3C7, "R1 transfer", dat(0), 12'h3C7);
    check(conv_start[0] == 1'b1, "R7 start", conv_start[0], 1);
    check(empty_evt[0] == 1'b1, "R8 empty evt", empty_evt[0], 1);
    tick();
    check(conv_start[0] == 1'b0 && empty_evt[0] == 1'b0, "R7 one cycle",
          {conv_start[0], empty_evt[0]}, 0);
    set_evt(0, 1'b0);
    check(dat(0) == 12'h3C7, "R1 fall ignored", dat(0), 12'h3C7);

    // R8 second transfer without buffer refill: no new empty event
    set_evt(0, 1'b1);
    check(empty_evt[0] == 1'b0, "R8 already empty", empty_evt[0], 0);
    set_evt(0, 1'b0);

    // R8 output enable clear gates the event
    empty_oe[0] = 1'b0;
    wr(0, 1'b1, 12'h055);
    set_evt(0, 1'b1);
    check(dat(0) == 12'h055 && empty_evt[0] == 1'b0, "R8 gated", empty_evt[0], 0);
    set_evt(0, 1'b0);
    empty_oe[0] = 1'b1;

    // R3 input event disabled
    start_ie[0] = 1'b0;
    wr(0, 1'b1, 12'h777);
    n0 = cs_cnt[0];
    set_evt(0, 1'b1);
    set_evt(0, 1'b0);
    check(dat(0) == 12'h055 && cs_cnt[0] == n0, "R3 ignored", dat(0), 12'h055);

    // R9 direct write with start_ie clear loads, with it set is ignored
    wr(0, 1'b0, 12'h9AB);
    check(dat(0) == 12'h9AB, "R9 direct", dat(0), 12'h9AB);
    start_ie[0] = 1'b1;
    wr(0, 1'b0, 12'h111);
    check(dat(0) == 12'h9AB, "R9 direct blocked", dat(0), 12'h9AB);

    // R2 falling edge selection
    start_inv[0] = 1'b1;
    wr(0, 1'b1, 12'h2D2);
    n0 = cs_cnt[0];
    set_evt(0, 1'b1);
    check(dat(0) == 12'h9AB && cs_cnt[0] == n0, "R2 rise ignored", dat(0), 12'h9AB);
    set_evt(0, 1'b0);
    check(dat(0) == 12'h2D2 && conv_start[0] == 1'b1, "R2 fall", dat(0), 12'h2D2);
    start_inv[0] = 1'b0;

    // R4 pending while not ready, two events, one conversion
    old1 = dat(1);
    conv_ready[0] = 1'b0;
    wr(0, 1'b1, 12'h6E1);
    n0 = cs_cnt[0];
    set_evt(0, 1'b1);
    set_evt(0, 1'b0);
    set_evt(0, 1'b1);
    set_evt(0, 1'b0);
    check(dat(0) == 12'h2D2 && cs_cnt[0] == n0, "R4 waits", dat(0), 12'h2D2);
    conv_ready[0] = 1'b1;
    tick();
    check(dat(0) == 12'h6E1 && conv_start[0] == 1'b1, "R4 go on ready", dat(0), 12'h6E1);
    tick(6);
    check(cs_cnt[0] == n0 + 1, "R4 single", cs_cnt[0] - n0, 1);

    // R10 channel 1 untouched by channel 0 activity
    check(dat(1) == old1 && cs_cnt[1] == 0, "R10 isolation", dat(1), old1);

    // R5 disable clears done
    ch_enable[1] = 1'b0;
    tick();
    check(startup_done[1] == 1'b0, "R5 disable", startup_done[1], 0);
    ch_enable[1] = 1'b1;
    tick(SU);
    start_ie = '1;

    // R1 R10 random traffic on both channels
    for (int it = 0; it < 40; it++) begin
      int c;
      logic [DW-1:0] other;
      c = $urandom % NCH;
      v = DW'($urandom);
      wr(c, 1'b1, v);
      other = dat(1 - c);
      start_evt[c] = ~start_evt[c];
      tick(3);
      if (start_evt[c]) begin
        check(dat(c) == v && conv_start[c] == 1'b1, "R1 random", dat(c), v);
      end else begin
        check(dat(c) != v || conv_start[c] == 1'b0, "R1 random fall", conv_start[c], 0);
      end
      check(dat(1 - c) == other, "R10 random", dat(1 - c), other);
    end

    finish_run();
  end
endmodule